// File: doc/BRIEF.md
# Current-Steered Three-Phase Carrier Modulator

This block turns three per-phase duty commands into gate pulses for an inverter in which every leg carries one upper and one lower active switch, and in each half-cycle only one of the two is ever modulated. A common zero-sequence offset is computed from the three duty commands and added to each phase. The result is clamped and compared against one shared symmetric triangle carrier. The pulse of each phase goes either to the upper switch or to the lower switch, chosen by the sign of that phase's current reference. The other switch of the leg is held off, so no dead time is needed.

A two-bit mode selects sinusoidal modulation (no offset), space-vector modulation (the offset is centred between the extreme duties), or discontinuous modulation. In discontinuous mode the offset pins one phase to a rail, and the choice follows the sign of the sum of the largest and smallest current references. That phase then stops switching while its current magnitude is the largest of the three. Duty commands are signed fixed point with FRAC_W fractional bits, so 1.0 is 2^FRAC_W. They may exceed 1.0 so that space-vector injection can reach about 1.15 of the sinusoidal limit. For a 20 kHz carrier, choose PRESCALE and FRAC_W so that the clock frequency divided by 4·PRESCALE·(2^FRAC_W−1) equals 20 kHz.

Top module: `dbuck_upwm`

## Requirements
- R1: A phase whose current reference is zero or positive (sign bit clear) drives PWM only on its upper gate, and its lower gate stays low for the whole carrier period.
- R2: A phase whose current reference is negative drives PWM only on its lower gate, and its upper gate stays low. The upper and lower gates of a leg are never high in the same cycle.
- R3: The carrier is a triangle with unit steps between −(2^FRAC_W−1) and +(2^FRAC_W−1). Each carrier value lasts PRESCALE clocks, so one period is 4·PRESCALE·(2^FRAC_W−1) clocks. Duties, offset and current signs are taken only when the carrier sits at its top or bottom value. With a modulated duty m, the upper gate is high for PRESCALE clocks for every carrier step below m, and the lower gate for every step above m.
- R4: Mode 0 (sinusoidal) adds no offset, so each modulated duty equals its duty command.
- R5: Mode 1 (space-vector) adds the offset −(dmax+dmin) shifted right arithmetically by one bit, where dmax and dmin are the largest and smallest duty commands.
- R6: Mode 2 (discontinuous) adds 1.0−dmax when the factor is high and −1.0−dmin when it is low. The phase with the extreme duty then sits at a rail and has no gate transition during the period.
- R7: The factor is recomputed at every carrier extreme in every mode from J, the sum of the largest and smallest current references. It is set high when J>0 and low when J<0, and keeps its value when J=0. Reset sets it high.
- R8: Each modulated duty is clamped to ±1.0 before comparison. A duty clamped to +1.0 keeps the selected gate on for the whole period, and one clamped to −1.0 keeps it off.
- R9: While reset is asserted all six gates are low, and they stay low until the first carrier extreme after reset is released.
- R10: Mode 3 behaves as mode 0.
- R11: In space-vector mode, a duty command of about 1.10 paired with two commands of about −0.55 is reproduced without clamping. The same command in sinusoidal mode is clamped to 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 sinusoidal, 1 space-vector, 2 discontinuous, 3 as 0 |
| duty_a | input | FRAC_W+2 | Signed duty command, phase a |
| duty_b | input | FRAC_W+2 | Signed duty command, phase b |
| duty_c | input | FRAC_W+2 | Signed duty command, phase c |
| iref_a | input | IREF_W | Signed current reference, phase a |
| iref_b | input | IREF_W | Signed current reference, phase b |
| iref_c | input | IREF_W | Signed current reference, phase c |
| gate_hi | output | 3 | Upper switch gates, bit 0 = phase a |
| gate_lo | output | 3 | Lower switch gates, bit 0 = phase a |

## Verification
Each stimulus is held for several carrier periods. The on-time and the number of rising edges of all six gates are then counted over one full period and compared with the counts expected from the modulated duties. Mixed current signs, including an exact zero, show the steering apart from the modulation itself. One pattern per mode, with duty sets that differ between the modes, shows the three offset rules apart. Discontinuous patterns with J positive, negative and then zero separate the factor update from the hold. Overdriven duties in space-vector and sinusoidal mode show where clamping happens and where injection avoids it.

// File: rtl/dbuck_upwm_pkg.sv
package dbuck_upwm_pkg;

   localparam int UPWM_NPH = 3;

   typedef enum logic [1:0] {
      UPWM_SINE = 2'd0,
      UPWM_SVEC = 2'd1,
      UPWM_DISC = 2'd2,
      UPWM_ALT  = 2'd3
   } upwm_mode_e;

endpackage

// File: rtl/dbuck_upwm_carrier.sv
module dbuck_upwm_carrier #(
   parameter int FRAC_W   = 8,
   parameter int PRESCALE = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic signed [FRAC_W+1:0] car,
   output logic                     smp
);
   localparam int CW = FRAC_W + 2;
   localparam logic signed [CW-1:0] CTOP = CW'((1 << FRAC_W) - 1);
   localparam logic signed [CW-1:0] CBOT = -CTOP;

   logic tick;
   logic up;

   generate
      if (PRESCALE == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(PRESCALE);
         logic [PW-1:0] pcnt;
         assign tick = (pcnt == PW'(PRESCALE - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)    pcnt <= '0;
            else if (tick) pcnt <= '0;
            else           pcnt <= pcnt + PW'(1);
         end
      end
   endgenerate

   assign smp = tick && ((car == CTOP) || (car == CBOT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         car <= CBOT;
         up  <= 1'b1;
      end else if (tick) begin
         if (up) begin
            if (car == CTOP - CW'(1)) up <= 1'b0;
            car <= car + CW'(1);
         end else begin
            if (car == CBOT + CW'(1)) up <= 1'b1;
            car <= car - CW'(1);
         end
      end
   end

   // R3
   car_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (car <= CTOP) && (car >= CBOT));

   // R3
   car_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(car) |-> ((car == $past(car) + CW'(1)) || (car == $past(car) - CW'(1))));

endmodule

// File: rtl/dbuck_upwm_zseq.sv
module dbuck_upwm_zseq
   import dbuck_upwm_pkg::*;
#(
   parameter int FRAC_W = 8,
   parameter int IREF_W = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      smp,
   input  logic [1:0]                mode,
   input  logic signed [FRAC_W+1:0]  duty [UPWM_NPH],
   input  logic signed [IREF_W-1:0]  iref [UPWM_NPH],
   output logic signed [FRAC_W+3:0]  dzs
);
   localparam int DW = FRAC_W + 2;
   localparam int SW = FRAC_W + 4;
   localparam int JW = IREF_W + 1;
   localparam logic signed [SW-1:0] FONE = SW'(1 << FRAC_W);

   logic signed [DW-1:0] dmax, dmin;
   logic signed [IREF_W-1:0] imax, imin;
   logic signed [SW-1:0] dmax_x, dmin_x;
   logic signed [JW-1:0] jsum;
   logic k0_q, k0_nx;
   upwm_mode_e md;

   always_comb begin
      dmax = duty[0];
      dmin = duty[0];
      imax = iref[0];
      imin = iref[0];
      for (int p = 1; p < UPWM_NPH; p++) begin
         if (duty[p] > dmax) dmax = duty[p];
         if (duty[p] < dmin) dmin = duty[p];
         if (iref[p] > imax) imax = iref[p];
         if (iref[p] < imin) imin = iref[p];
      end
   end

   assign dmax_x = SW'(dmax);
   assign dmin_x = SW'(dmin);
   assign jsum   = JW'(imax) + JW'(imin);
   assign md     = upwm_mode_e'(mode);

   always_comb begin
      if (jsum > JW'(0))      k0_nx = 1'b1;
      else if (jsum < JW'(0)) k0_nx = 1'b0;
      else                    k0_nx = k0_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   k0_q <= 1'b1;
      else if (smp) k0_q <= k0_nx;
   end

   always_comb begin
      case (md)
         UPWM_SVEC: dzs = (-(dmax_x + dmin_x)) >>> 1;
         UPWM_DISC: dzs = k0_nx ? (FONE - dmax_x) : (-FONE - dmin_x);
         default:   dzs = '0;
      endcase
   end

   // R7
   k0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && (jsum == JW'(0))) |=> $stable(k0_q));

   // R7
   k0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp |=> $stable(k0_q));

endmodule

// File: rtl/dbuck_upwm_leg.sv
module dbuck_upwm_leg #(
   parameter int FRAC_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp,
   input  logic signed [FRAC_W+1:0] duty,
   input  logic                     iref_neg,
   input  logic signed [FRAC_W+3:0] dzs,
   input  logic signed [FRAC_W+1:0] car,
   output logic                     gate_hi,
   output logic                     gate_lo
);
   localparam int CW = FRAC_W + 2;
   localparam int SW = FRAC_W + 4;
   localparam logic signed [SW-1:0] SPOS = SW'(1 << FRAC_W);
   localparam logic signed [CW-1:0] CPOS = CW'(1 << FRAC_W);

   logic signed [SW-1:0] sum;
   logic signed [CW-1:0] mod_nx, mod_q;
   logic pos_q, armed;

   assign sum = SW'(duty) + dzs;

   always_comb begin
      if (sum > SPOS)       mod_nx = CPOS;
      else if (sum < -SPOS) mod_nx = -CPOS;
      else                  mod_nx = CW'(sum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mod_q <= '0;
         pos_q <= 1'b1;
         armed <= 1'b0;
      end else if (smp) begin
         mod_q <= mod_nx;
         pos_q <= !iref_neg;
         armed <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_hi <= 1'b0;
         gate_lo <= 1'b0;
      end else begin
         gate_hi <= armed && pos_q && (mod_q > car);
         gate_lo <= armed && !pos_q && (mod_q < car);
      end
   end

   // R2
   leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   // R1
   leg_lo_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_lo |-> !$past(pos_q));

   // R3
   leg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp |=> $stable(mod_q));

   // R8
   leg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_q <= CPOS) && (mod_q >= -CPOS));

endmodule

// File: rtl/dbuck_upwm.sv
module dbuck_upwm
   import dbuck_upwm_pkg::*;
#(
   parameter int FRAC_W   = 8,
   parameter int IREF_W   = 12,
   parameter int PRESCALE = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               mode,
   input  logic signed [FRAC_W+1:0] duty_a,
   input  logic signed [FRAC_W+1:0] duty_b,
   input  logic signed [FRAC_W+1:0] duty_c,
   input  logic signed [IREF_W-1:0] iref_a,
   input  logic signed [IREF_W-1:0] iref_b,
   input  logic signed [IREF_W-1:0] iref_c,
   output logic [2:0]               gate_hi,
   output logic [2:0]               gate_lo
);
   localparam int DW = FRAC_W + 2;
   localparam int SW = FRAC_W + 4;

   generate
      if (FRAC_W < 4 || FRAC_W > 16) begin : g_bad_frac
         $error("FRAC_W must lie in 4..16");
      end
      if (IREF_W < 2) begin : g_bad_iref
         $error("IREF_W must be at least 2");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
   endgenerate

   logic signed [DW-1:0]     duty_v [UPWM_NPH];
   logic signed [IREF_W-1:0] iref_v [UPWM_NPH];
   logic signed [DW-1:0]     car;
   logic signed [SW-1:0]     dzs;
   logic                     smp;

   assign duty_v[0] = duty_a;
   assign duty_v[1] = duty_b;
   assign duty_v[2] = duty_c;
   assign iref_v[0] = iref_a;
   assign iref_v[1] = iref_b;
   assign iref_v[2] = iref_c;

   dbuck_upwm_carrier #(.FRAC_W(FRAC_W), .PRESCALE(PRESCALE)) u_car (
      .clk(clk), .rst_n(rst_n), .car(car), .smp(smp)
   );

   dbuck_upwm_zseq #(.FRAC_W(FRAC_W), .IREF_W(IREF_W)) u_zseq (
      .clk(clk), .rst_n(rst_n), .smp(smp), .mode(mode),
      .duty(duty_v), .iref(iref_v), .dzs(dzs)
   );

   generate
      for (genvar g = 0; g < UPWM_NPH; g++) begin : g_leg
         dbuck_upwm_leg #(.FRAC_W(FRAC_W)) u_leg (
            .clk(clk), .rst_n(rst_n), .smp(smp),
            .duty(duty_v[g]), .iref_neg(iref_v[g][IREF_W-1]),
            .dzs(dzs), .car(car),
            .gate_hi(gate_hi[g]), .gate_lo(gate_lo[g])
         );
      end
   endgenerate

endmodule

// File: tb/test_dbuck_upwm.sv
module test_dbuck_upwm;
   localparam int FRAC_W = 8;
   localparam int IREF_W = 12;
   localparam int PRE    = 2;
   localparam int ONE    = 1 << FRAC_W;
   localparam int CM     = ONE - 1;
   localparam int PER    = 4 * PRE * CM;
   localparam int NPAT   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic signed [FRAC_W+1:0] duty_a = '0, duty_b = '0, duty_c = '0;
   logic signed [IREF_W-1:0] iref_a = '0, iref_b = '0, iref_c = '0;
   logic [2:0] gate_hi, gate_lo;

   int total = 0;
   int bad = 0;
   int done_cnt = 0;
   int issued = 0;
   int k0_m = 1;
   int q[$];
   int e_hi [NPAT][3];
   int e_lo [NPAT][3];
   int e_pos[NPAT][3];
   string e_tag[NPAT];

   always #4 clk = ~clk;

   dbuck_upwm #(.FRAC_W(FRAC_W), .IREF_W(IREF_W), .PRESCALE(PRE)) i_dbuck_upwm (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
      .iref_a(iref_a), .iref_b(iref_b), .iref_c(iref_c),
      .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // on-clocks over one period: carrier steps below m (upper) or above m (lower)
   function automatic int cnt_gt(input int m);
      int n = 0;
      for (int c = -CM; c <= CM; c++)
         if (m > c) n += ((c == CM) || (c == -CM)) ? 1 : 2;
      return n * PRE;
   endfunction

   function automatic int cnt_lt(input int m);
      int n = 0;
      for (int c = -CM; c <= CM; c++)
         if (m < c) n += ((c == CM) || (c == -CM)) ? 1 : 2;
      return n * PRE;
   endfunction

   task automatic apply(input int md, input int da, input int db, input int dc,
                        input int ia, input int ib, input int ic, input string tag);
      int d[3];
      int i[3];
      int dmax, dmin, imax, imin, jj, dz, m;
      int id;
      d = '{da, db, dc};
      i = '{ia, ib, ic};
      dmax = d[0]; dmin = d[0]; imax = i[0]; imin = i[0];
      for (int p = 1; p < 3; p++) begin
         if (d[p] > dmax) dmax = d[p];
         if (d[p] < dmin) dmin = d[p];
         if (i[p] > imax) imax = i[p];
         if (i[p] < imin) imin = i[p];
      end
      jj = imax + imin;
      if (jj > 0) k0_m = 1;
      else if (jj < 0) k0_m = 0;
      if (md == 1)      dz = (-(dmax + dmin)) >>> 1;
      else if (md == 2) dz = (k0_m == 1) ? (ONE - dmax) : (-ONE - dmin);
      else              dz = 0;
      id = issued;
      e_tag[id] = tag;
      for (int p = 0; p < 3; p++) begin
         m = d[p] + dz;
         if (m > ONE) m = ONE;
         if (m < -ONE) m = -ONE;
         e_pos[id][p] = (i[p] >= 0) ? 1 : 0;
         e_hi[id][p]  = (i[p] >= 0) ? cnt_gt(m) : 0;
         e_lo[id][p]  = (i[p] >= 0) ? 0 : cnt_lt(m);
      end
      @(negedge clk);
      mode   = 2'(md);
      duty_a = (FRAC_W+2)'(da); duty_b = (FRAC_W+2)'(db); duty_c = (FRAC_W+2)'(dc);
      iref_a = IREF_W'(ia);     iref_b = IREF_W'(ib);     iref_c = IREF_W'(ic);
      issued++;
      q.push_back(id);
      wait (done_cnt == issued);
   endtask

   // monitor: pops an expected item, lets the modulator settle, counts one period
   initial begin
      forever begin
         int id;
         int nh[3], nl[3], rh[3], rl[3];
         int both;
         logic [2:0] ph, pl;
         wait (q.size() > 0);
         id = q.pop_front();
         repeat (2 * PER) @(negedge clk);
         ph = gate_hi; pl = gate_lo;
         nh = '{0, 0, 0}; nl = '{0, 0, 0}; rh = '{0, 0, 0}; rl = '{0, 0, 0};
         both = 0;
         for (int n = 0; n < PER; n++) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
               if (gate_hi[p]) nh[p]++;
               if (gate_lo[p]) nl[p]++;
               if (gate_hi[p] && !ph[p]) rh[p]++;
               if (gate_lo[p] && !pl[p]) rl[p]++;
               if (gate_hi[p] && gate_lo[p]) both++;
            end
            ph = gate_hi; pl = gate_lo;
         end
         for (int p = 0; p < 3; p++) begin
            int xr;
            chk(nh[p] == e_hi[id][p], e_tag[id], $sformatf("upper on-clocks phase %0d", p), nh[p], e_hi[id][p]);
            chk(nl[p] == e_lo[id][p], e_tag[id], $sformatf("lower on-clocks phase %0d", p), nl[p], e_lo[id][p]);
            if (e_pos[id][p] == 1) begin
               // R1: lower gate held off for non-negative reference
               chk(nl[p] == 0, "R1", $sformatf("lower idle phase %0d", p), nl[p], 0);
               xr = (e_hi[id][p] == 0 || e_hi[id][p] == PER) ? 0 : 1;
               chk(rh[p] == xr, e_tag[id], $sformatf("upper rises phase %0d", p), rh[p], xr);
            end else begin
               // R2: upper gate held off for negative reference
               chk(nh[p] == 0, "R2", $sformatf("upper idle phase %0d", p), nh[p], 0);
               xr = (e_lo[id][p] == 0 || e_lo[id][p] == PER) ? 0 : 1;
               chk(rl[p] == xr, e_tag[id], $sformatf("lower rises phase %0d", p), rl[p], xr);
            end
         end
         // R2: never both gates of a leg
         chk(both == 0, "R2", "cycles with both gates high", both, 0);
         done_cnt++;
      end
   end

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      duty_a = (FRAC_W+2)'(ONE);
      iref_a = IREF_W'(5);
      repeat (5) @(negedge clk);
      // R9: gates low in reset
      chk(gate_hi == 3'b000, "R9", "upper gates in reset", int'(gate_hi), 0);
      chk(gate_lo == 3'b000, "R9", "lower gates in reset", int'(gate_lo), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: still low before the first carrier extreme
      chk(gate_hi == 3'b000, "R9", "upper gates before first sample", int'(gate_hi), 0);
      chk(gate_lo == 3'b000, "R9", "lower gates before first sample", int'(gate_lo), 0);

      // R3 R4 R1: sinusoidal, zero reference on phase c counts as positive
      apply(0, 128, -64, 0, 5, -5, 0, "R3 R4");
      // R5: space-vector, centred offset
      apply(1, 200, -100, -100, 4, 2, -3, "R5");
      // R6: discontinuous, J>0, phase a pinned high
      apply(2, 200, -60, -140, 10, -3, -7, "R6");
      // R6: discontinuous, J<0, phase b pinned low on the lower switch
      apply(2, 60, -200, 140, 3, -10, 7, "R6");
      // R7: J=0 keeps the low factor
      apply(2, 100, -100, 0, 5, -5, 0, "R7");
      apply(2, 200, -60, -140, 10, -3, -7, "R6");
      // R7: J=0 keeps the high factor
      apply(2, 100, 0, -100, 5, 0, -5, "R7");
      // R8 R10: mode 3 acts as sinusoidal, overdriven duties clamp
      apply(3, 300, -300, 50, 1, -1, 1, "R8 R10");
      // R11: space-vector reproduces about 1.10 without clamping
      apply(1, 282, -141, -141, 1, -1, -1, "R11");
      // R11: same command in sinusoidal mode clamps
      apply(0, 282, -141, -141, 1, -1, -1, "R11");
      // R5: odd negative sum, arithmetic shift rounds toward minus infinity
      apply(1, -3, 0, 0, -2, 2, 2, "R5");
      finish_run();
   end

endmodule